// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block decides, cycle by cycle, how a three-stage pipeline (fetch/decode, execute, memory/writeback) resolves its hazards. Two pipeline registers sit between the stages: one between decode and execute, one between execute and memory/writeback. The block looks at the register numbers carried by each stage and drives three kinds of control. It picks the ALU operand sources. It gates the PC and the front pipeline register. It zeroes the control word that enters the execute stage.

Memory access and writeback share one stage, so only one stage can forward a result: the memory/writeback stage, back to the execute stage. The one dependence that forwarding cannot cover is a load whose result is needed by the very next instruction. The block handles it with a single stall cycle. Control transfers follow a predict-not-taken policy. A branch that falls through costs nothing. A taken branch, or any jump, squashes the instructions that were wrongly fetched behind it for a fixed number of cycles, set by a parameter. The datapath, the ALU and the register file belong to the surrounding core.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `fwd_a` is 1 (take the memory/writeback result) exactly when `wb_we`=1, `wb_rd`≠0 and `wb_rd`=`ex_rs`. Otherwise it is 0 (take the register file value).
- R2: `fwd_b` follows the same rule as R1, with `ex_rt` as the source register.
- R3: Register number 0 never causes forwarding (as `wb_rd`) and never causes a load-use stall (as `ex_rd`).
- R4: When `ex_memread`=1, `ex_rd`≠0 and `ex_rd` equals `id_rs` or `id_rt`, and no flush is in progress, the block drives `pc_we`=0, `ifid_we`=0 and `idex_zero`=1 in that same cycle.
- R5: A load whose destination matches neither decode source does not stall. With no hazard present, the outputs are `pc_we`=1, `ifid_we`=1 and `idex_zero`=0, so a not-taken branch adds no cycles.
- R6: When `ex_taken`=1, `idex_zero` is 1 in that cycle and in the FLUSH_CYCLES-1 cycles that follow. During this window `pc_we` and `ifid_we` stay 1 so that the redirected fetch proceeds.
- R7: `ex_jump`=1 starts the same flush window as a taken branch.
- R8: While a flush is in progress, a load-use match does not stall: `pc_we` and `ifid_we` stay 1.
- R9: A synchronous reset clears any flush in progress. After reset, quiet inputs give `pc_we`=1, `ifid_we`=1, `idex_zero`=0 and both forward selects 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs | input | REG_AW | First source register of the execute-stage instruction |
| ex_rt | input | REG_AW | Second source register of the execute-stage instruction |
| wb_rd | input | REG_AW | Destination register of the memory/writeback-stage instruction |
| wb_we | input | 1 | Memory/writeback-stage instruction writes a register |
| id_rs | input | REG_AW | First source register of the decode-stage instruction |
| id_rt | input | REG_AW | Second source register of the decode-stage instruction |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_taken | input | 1 | Branch in the execute stage resolved taken |
| ex_jump | input | 1 | Jump or jump-and-link in the execute stage |
| fwd_a | output | 1 | First ALU operand select: 0 register file, 1 memory/writeback result |
| fwd_b | output | 1 | Second ALU operand select: 0 register file, 1 memory/writeback result |
| pc_we | output | 1 | PC update enable |
| ifid_we | output | 1 | Front pipeline register load enable |
| idex_zero | output | 1 | Force the control word entering execute to zero |

## Verification
The bench builds the block with REG_AW=5 and FLUSH_CYCLES=3. A three-cycle window shows whether the flush counter reloads, counts down and releases on the right edge; with the default of 2 it would only have to end one cycle after it starts. With that window the bench can also place a load-use match in the middle of a flush to test priority, and it can reset the block partway through a flush. Register 0 and the all-ones register number both appear as sources and destinations, so the zero exclusion and full-width comparisons are both exercised.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic {
    OPND_RF = 1'b0,
    OPND_WB = 1'b1
  } opnd_sel_e;
endpackage

// File: rtl/hzc_fwd_unit.sv
module hzc_fwd_unit
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic [NSRC-1:0][REG_AW-1:0] src_reg,
  input  logic [REG_AW-1:0]           wb_dst,
  input  logic                        wb_wr,
  output logic [NSRC-1:0]             sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic wb_live;
  assign wb_live = wb_wr && (wb_dst != ZERO_REG);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    opnd_sel_e s;
    always_comb begin
      s = OPND_RF;
      if (wb_live && (src_reg[i] == wb_dst)) s = OPND_WB;
    end
    assign sel[i] = s;
  end
endmodule

// File: rtl/hzc_loaduse_unit.sv
module hzc_loaduse_unit #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic [NSRC-1:0][REG_AW-1:0] dec_src,
  input  logic [REG_AW-1:0]           ld_dst,
  input  logic                        ld_active,
  output logic                        hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] match;
  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign match[i] = (dec_src[i] == ld_dst);
  end

  assign hit = ld_active && (ld_dst != ZERO_REG) && (|match);
endmodule

// File: rtl/hzc_flush_unit.sv
module hzc_flush_unit #(
  parameter int FLUSH_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic redirect,
  output logic squash
);
  localparam int CW = $clog2(FLUSH_CYCLES) + 1;
  localparam logic [CW-1:0] RELOAD = CW'(FLUSH_CYCLES - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (redirect) begin
      left_q <= RELOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign squash = redirect || (left_q != '0);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_AW       = 5,
  parameter int FLUSH_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_memread,
  input  logic              ex_taken,
  input  logic              ex_jump,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_zero
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0][REG_AW-1:0] id_src;
  logic [NSRC-1:0]             sel;
  logic                        lu_hit;
  logic                        squash;

  assign ex_src = {ex_rt, ex_rs};
  assign id_src = {id_rt, id_rs};

  hzc_fwd_unit #(.REG_AW(REG_AW), .NSRC(NSRC)) u_fwd (
    .src_reg (ex_src),
    .wb_dst  (wb_rd),
    .wb_wr   (wb_we),
    .sel     (sel)
  );

  hzc_loaduse_unit #(.REG_AW(REG_AW), .NSRC(NSRC)) u_lu (
    .dec_src   (id_src),
    .ld_dst    (ex_rd),
    .ld_active (ex_memread),
    .hit       (lu_hit)
  );

  hzc_flush_unit #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_fl (
    .clk      (clk),
    .rst      (rst),
    .redirect (ex_taken || ex_jump),
    .squash   (squash)
  );

  logic hold;
  assign hold = lu_hit && !squash;

  assign fwd_a     = sel[0];
  assign fwd_b     = sel[1];
  assign pc_we     = !hold;
  assign ifid_we   = !hold;
  assign idex_zero = squash || hold;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_AW       = 5,
  parameter int FLUSH_CYCLES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] ex_rs,
  input logic [REG_AW-1:0] ex_rt,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_we,
  input logic [REG_AW-1:0] id_rs,
  input logic [REG_AW-1:0] id_rt,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_memread,
  input logic              ex_taken,
  input logic              ex_jump,
  input logic              fwd_a,
  input logic              fwd_b,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              idex_zero
);
  a_r1_fwd_a: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_rd != '0 && wb_rd == ex_rs) |-> fwd_a);
  a_r2_fwd_b: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_rd != '0 && wb_rd == ex_rt) |-> fwd_b);
  a_r3_zero_no_fwd: assert property (@(posedge clk) disable iff (rst)
    (wb_rd == '0 || !wb_we) |-> (!fwd_a && !fwd_b));
  a_r4_stall: assert property (@(posedge clk) disable iff (rst)
    (!pc_we) |-> (!ifid_we && idex_zero));
  a_r6_flush_now: assert property (@(posedge clk) disable iff (rst)
    ex_taken |-> (idex_zero && pc_we && ifid_we));
  a_r6_flush_next: assert property (@(posedge clk) disable iff (rst)
    (FLUSH_CYCLES >= 2 && ex_taken) |=> idex_zero);
  a_r7_jump: assert property (@(posedge clk) disable iff (rst)
    ex_jump |-> (idex_zero && pc_we));
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ex_memread && !ex_taken && !ex_jump) |-> (pc_we && ifid_we));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
  .REG_AW(REG_AW), .FLUSH_CYCLES(FLUSH_CYCLES)
) u_chk (.*);

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
  localparam int AW = 5;
  localparam int FC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ex_rs = '0, ex_rt = '0, wb_rd = '0, id_rs = '0, id_rt = '0, ex_rd = '0;
  logic wb_we = 1'b0, ex_memread = 1'b0, ex_taken = 1'b0, ex_jump = 1'b0;
  logic fwd_a, fwd_b, pc_we, ifid_we, idex_zero;

  always #2 clk = ~clk;

  pipe_hazard_ctrl #(.REG_AW(AW), .FLUSH_CYCLES(FC)) dut (.*);

  typedef struct {
    logic [4:0] v;
    string      req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int flush_left = 0;
  bit done = 1'b0;

  // v = {fwd_a, fwd_b, pc_we, ifid_we, idex_zero}
  task automatic step(input logic [AW-1:0] rs_e, rt_e, rd_w, input logic we,
                      input logic [AW-1:0] rs_d, rt_d, rd_e, input logic ld,
                      input logic tk, jp, input string req);
    logic ea, eb, fl, st;
    exp_t e;
    @(posedge clk); #1;
    ex_rs = rs_e; ex_rt = rt_e; wb_rd = rd_w; wb_we = we;
    id_rs = rs_d; id_rt = rt_d; ex_rd = rd_e; ex_memread = ld;
    ex_taken = tk; ex_jump = jp;
    ea = we && rd_w != 0 && rd_w == rs_e;
    eb = we && rd_w != 0 && rd_w == rt_e;
    fl = tk || jp || flush_left > 0;
    st = ld && rd_e != 0 && (rd_e == rs_d || rd_e == rt_d) && !fl;
    if (tk || jp) flush_left = FC - 1;
    else if (flush_left > 0) flush_left--;
    e.v = {ea, eb, !st, !st, fl || st};
    e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {fwd_a, fwd_b, pc_we, ifid_we, idex_zero};
      total++;
      if (act !== e.v) begin
        bad++;
        $display("FAIL %s: got %b expected %b", e.req, act, e.v);
      end
    end
  end

  task automatic quiet(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    quiet("R9 reset state");
    // R1 / R2 forwarding
    step(5'd3, 5'd7, 5'd3, 1, 0, 0, 0, 0, 0, 0, "R1 fwd A");
    step(5'd3, 5'd7, 5'd7, 1, 0, 0, 0, 0, 0, 0, "R2 fwd B");
    step(5'd9, 5'd9, 5'd9, 1, 0, 0, 0, 0, 0, 0, "R1 R2 both");
    step(5'd31, 5'd4, 5'd31, 0, 0, 0, 0, 0, 0, 0, "R1 no write");
    step(5'd31, 5'd30, 5'd31, 1, 0, 0, 0, 0, 0, 0, "R1 top reg");
    // R3 zero register
    step(5'd0, 5'd0, 5'd0, 1, 0, 0, 0, 0, 0, 0, "R3 no fwd r0");
    step(0, 0, 0, 0, 5'd0, 5'd0, 5'd0, 1, 0, 0, "R3 no stall r0");
    // R4 load-use
    step(0, 0, 0, 0, 5'd6, 5'd2, 5'd6, 1, 0, 0, "R4 stall rs");
    step(0, 0, 0, 0, 5'd1, 5'd12, 5'd12, 1, 0, 0, "R4 stall rt");
    step(5'd12, 0, 5'd12, 1, 5'd1, 5'd2, 0, 0, 0, 0, "R1 after stall");
    // R5 no hazard
    step(0, 0, 0, 0, 5'd1, 5'd2, 5'd3, 1, 0, 0, "R5 load no match");
    step(0, 0, 0, 0, 5'd3, 5'd3, 5'd3, 0, 0, 0, "R5 non-load match");
    quiet("R5 branch not taken");
    // R6 taken branch window
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 taken");
    quiet("R6 window 2");
    quiet("R6 window 3");
    quiet("R6 window end");
    // R7 jump plus R8 priority within window
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 jump");
    step(0, 0, 0, 0, 5'd8, 5'd0, 5'd8, 1, 0, 0, "R8 flush over stall");
    quiet("R7 window 3");
    step(0, 0, 0, 0, 5'd8, 5'd0, 5'd8, 1, 0, 0, "R4 stall after window");
    step(0, 0, 0, 0, 5'd8, 5'd0, 5'd8, 1, 1, 0, "R8 taken with load match");
    // R9 reset mid-flush
    @(posedge clk); #1;
    ex_taken = 1'b0; ex_memread = 1'b0; rst = 1'b1;
    flush_left = 0;
    @(posedge clk); #1 rst = 1'b0;
    quiet("R9 reset clears flush");
    quiet("R9 quiet after reset");
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule